// File: doc/BRIEF.md
# Operand Criticality Predictor and Lane Steering

In a clustered processor, operands, loads, stores and addresses cross between clusters over an interconnect that has two lanes. One lane is fast and costly in power. The other is slow and cheap. This block decides, for each transfer request, which lane the value should take. Some transfer kinds follow a fixed rule. Values forwarded from a producer that has just completed depend on a learned per-instruction prediction: is the consumer waiting for them, or will they sit unused for a while?

The prediction is kept in a table of 2-bit saturating counters, selected by the low bits of the producing instruction's address. At run time, training reports give the cycle an operand reached its consumer's cluster and the cycle that consumer issued. The gap between them is the slack. It is compared with a writable threshold, and the counter is moved toward critical or non-critical. Lookups read the table combinationally, so a request is steered in the cycle it is presented.

Top module: `crit_steer_top`

## Requirements
- R1: The table entry used by a request or a training report is selected by the instruction address bits [IDX_W-1:0]. Two addresses that differ only above those bits share one entry.
- R2: Each entry is a 2-bit saturating counter that resets to 2 (weakly critical). Its upper bit is the critical prediction, so every entry predicts critical after reset.
- R3: A training report has slack = issue cycle minus arrival cycle. Slack strictly below the threshold, including negative slack, increments the entry, saturating at 3. Slack equal to or above the threshold decrements it, saturating at 0.
- R4: The threshold register resets to THR_INIT (default 4). It loads thr_data in any cycle where thr_wr is high and otherwise holds its value.
- R5: Type code 2 (load result) always selects the fast lane (lane_sel=1). Type code 3 (store data) always selects the slow lane (lane_sel=0).
- R6: Type code 0 (register value already ready at dispatch) always selects the slow lane.
- R7: Type code 4 (effective address) selects the fast lane when req_addr_pred is 0 and the slow lane when it is 1.
- R8: Type code 1 (bypassed register value) selects the lane equal to the table prediction for req_pc.
- R9: The unused type codes 5, 6 and 7 select the fast lane.
- R10: When a lookup and a training update hit the same entry in the same cycle, the lookup returns the value from before the update. The update is visible from the next cycle.
- R11: While req_valid is low, lane_sel and pred_crit are both 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A transfer request is present this cycle |
| req_type | input | 3 | Transfer type code |
| req_pc | input | PC_W | Address of the producing instruction |
| req_addr_pred | input | 1 | Address transfer only verifies a predicted address |
| lane_sel | output | 1 | 1 = fast lane, 0 = slow lane |
| pred_crit | output | 1 | Table prediction for req_pc |
| trn_valid | input | 1 | A training report is present this cycle |
| trn_pc | input | PC_W | Address of the instruction being trained |
| trn_arrive | input | CYC_W | Cycle the operand arrived at the consumer |
| trn_issue | input | CYC_W | Cycle the consumer issued |
| thr_wr | input | 1 | Load the slack threshold |
| thr_data | input | CYC_W | New threshold value |

## Verification
Every combination of type code, predicted-address flag and table entry is looked up in turn, with the entries holding a mix of critical and non-critical predictions. This separates the fixed per-type rules from the table-driven path and shows that unused codes fall to the fast lane. Training reports sweep slack from negative values through the threshold and beyond it. The trained address differs from the looked-up one only in its upper bits, so the sweep shows the strict comparison at equality, counter saturation at both ends, and index aliasing. A threshold rewrite, a same-cycle update and lookup on one entry, and idle-request cycles cover the remaining rules.

// File: rtl/crit_pkg.sv
package crit_pkg;

  // transfer type codes
  localparam logic [2:0] XF_READY  = 3'd0;
  localparam logic [2:0] XF_BYPASS = 3'd1;
  localparam logic [2:0] XF_LOAD   = 3'd2;
  localparam logic [2:0] XF_STORE  = 3'd3;
  localparam logic [2:0] XF_ADDR   = 3'd4;

  localparam logic LANE_FAST = 1'b1;
  localparam logic LANE_SLOW = 1'b0;

  localparam logic [1:0] CTR_INIT = 2'd2;
  localparam logic [1:0] CTR_MAX  = 2'd3;
  localparam logic [1:0] CTR_MIN  = 2'd0;

  // one saturating step of a 2-bit confidence counter
  function automatic logic [1:0] sat_step(input logic [1:0] cur, input logic up);
    logic [1:0] nxt;
    if (up) nxt = (cur == CTR_MAX) ? CTR_MAX : cur + 2'd1;
    else    nxt = (cur == CTR_MIN) ? CTR_MIN : cur - 2'd1;
    return nxt;
  endfunction

  // fixed routing rule per transfer type; bypass follows the prediction
  function automatic logic pick_lane(input logic [2:0] xt, input logic apred,
                                     input logic crit);
    logic l;
    case (xt)
      XF_READY:  l = LANE_SLOW;
      XF_BYPASS: l = crit ? LANE_FAST : LANE_SLOW;
      XF_LOAD:   l = LANE_FAST;
      XF_STORE:  l = LANE_SLOW;
      XF_ADDR:   l = apred ? LANE_SLOW : LANE_FAST;
      default:   l = LANE_FAST;
    endcase
    return l;
  endfunction

endpackage

// File: rtl/crit_table.sv
module crit_table #(
  parameter int IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [1:0]       rd_ctr,
  input  logic             upd_en,
  input  logic [IDX_W-1:0] upd_idx,
  input  logic             upd_up
);
  import crit_pkg::*;

  localparam int ENTRIES = 1 << IDX_W;

  logic [1:0] ctr_q [ENTRIES];
  logic [1:0] upd_old;
  logic [1:0] upd_new;

  assign upd_old = ctr_q[upd_idx];
  assign upd_new = sat_step(upd_old, upd_up);
  assign rd_ctr  = ctr_q[rd_idx];   // old value even if updated this cycle

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) ctr_q[i] <= CTR_INIT;
    end else if (upd_en) begin
      ctr_q[upd_idx] <= upd_new;
    end
  end

  // observation of the entry touched in the previous cycle
  logic [IDX_W-1:0] last_idx;
  logic [1:0]       last_ctr;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_idx <= '0;
    else        last_idx <= upd_idx;
  end
  assign last_ctr = ctr_q[last_idx];

  // R2
  ctr_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en && upd_up) |=> (last_ctr >= $past(upd_old)));
  // R2
  ctr_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en && !upd_up) |=> (last_ctr <= $past(upd_old)));
  // R10
  rd_old_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en && (rd_idx == upd_idx)) |-> (rd_ctr == upd_old));

endmodule

// File: rtl/crit_slack.sv
module crit_slack #(
  parameter int CYC_W    = 16,
  parameter int THR_INIT = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             thr_wr,
  input  logic [CYC_W-1:0] thr_data,
  input  logic [CYC_W-1:0] arrive,
  input  logic [CYC_W-1:0] issue,
  output logic             train_up
);

  logic [CYC_W-1:0] thr_q;

  // slack below the threshold (negative slack included) means critical
  function automatic logic slack_crit(input logic [CYC_W-1:0] arr,
                                      input logic [CYC_W-1:0] iss,
                                      input logic [CYC_W-1:0] thr);
    logic [CYC_W:0] gap;
    gap = {1'b0, iss} - {1'b0, arr};
    return gap[CYC_W] || (gap[CYC_W-1:0] < thr);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      thr_q <= CYC_W'(THR_INIT);
    else if (thr_wr) thr_q <= thr_data;
  end

  assign train_up = slack_crit(arrive, issue, thr_q);

  // R4
  thr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    thr_wr |=> (thr_q == $past(thr_data)));
  // R4
  thr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !thr_wr |=> $stable(thr_q));
  // R3
  neg_slack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (issue < arrive) |-> train_up);
  // R3
  at_thr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((issue >= arrive) && ((issue - arrive) == thr_q)) |-> !train_up);

endmodule

// File: rtl/crit_steer.sv
module crit_steer (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] xtype,
  input  logic       addr_pred,
  input  logic       crit,
  output logic       fast
);
  import crit_pkg::*;

  assign fast = pick_lane(xtype, addr_pred, crit);

  // R5
  load_fast_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xtype == XF_LOAD) |-> fast);
  // R5
  store_slow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xtype == XF_STORE) |-> !fast);
  // R6
  ready_slow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xtype == XF_READY) |-> !fast);
  // R7
  addr_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xtype == XF_ADDR) |-> (fast == !addr_pred));

endmodule

// File: rtl/crit_steer_top.sv
module crit_steer_top #(
  parameter int PC_W     = 32,
  parameter int IDX_W    = 6,
  parameter int CYC_W    = 16,
  parameter int THR_INIT = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [2:0]       req_type,
  input  logic [PC_W-1:0]  req_pc,
  input  logic             req_addr_pred,
  output logic             lane_sel,
  output logic             pred_crit,
  input  logic             trn_valid,
  input  logic [PC_W-1:0]  trn_pc,
  input  logic [CYC_W-1:0] trn_arrive,
  input  logic [CYC_W-1:0] trn_issue,
  input  logic             thr_wr,
  input  logic [CYC_W-1:0] thr_data
);
  import crit_pkg::*;

  logic [IDX_W-1:0] rd_idx;
  logic [IDX_W-1:0] upd_idx;
  logic [1:0]       rd_ctr;
  logic             train_up;
  logic             tbl_crit;
  logic             steer_fast;

  assign rd_idx  = req_pc[IDX_W-1:0];
  assign upd_idx = trn_pc[IDX_W-1:0];

  // upper address bits do not take part in indexing
  logic unused_pc_hi;
  assign unused_pc_hi = ^{req_pc[PC_W-1:IDX_W], trn_pc[PC_W-1:IDX_W]};

  crit_slack #(.CYC_W(CYC_W), .THR_INIT(THR_INIT)) u_slack (
    .clk      (clk),
    .rst_n    (rst_n),
    .thr_wr   (thr_wr),
    .thr_data (thr_data),
    .arrive   (trn_arrive),
    .issue    (trn_issue),
    .train_up (train_up)
  );

  crit_table #(.IDX_W(IDX_W)) u_table (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_idx  (rd_idx),
    .rd_ctr  (rd_ctr),
    .upd_en  (trn_valid),
    .upd_idx (upd_idx),
    .upd_up  (train_up)
  );

  assign tbl_crit = rd_ctr[1];

  crit_steer u_steer (
    .clk       (clk),
    .rst_n     (rst_n),
    .xtype     (req_type),
    .addr_pred (req_addr_pred),
    .crit      (tbl_crit),
    .fast      (steer_fast)
  );

  assign lane_sel  = req_valid & steer_fast;
  assign pred_crit = req_valid & tbl_crit;

  // R8
  bypass_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_type == XF_BYPASS) |-> (lane_sel == pred_crit));
  // R9
  spare_fast_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_type > XF_ADDR) |-> lane_sel);
  // R11
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> (!lane_sel && !pred_crit));

endmodule

// File: tb/crit_steer_top_tb.sv
`timescale 1ns/1ps
module crit_steer_top_tb;
  localparam int PC_W = 16, IDX_W = 3, CYC_W = 8, THR0 = 4;
  localparam int N = 1 << IDX_W;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_addr_pred = 0;
  logic [2:0] req_type = 0;
  logic [PC_W-1:0] req_pc = 0, trn_pc = 0;
  logic lane_sel, pred_crit;
  logic trn_valid = 0, thr_wr = 0;
  logic [CYC_W-1:0] trn_arrive = 0, trn_issue = 0, thr_data = 0;

  int checks = 0, errors = 0;
  int mdl [N];
  int thr = THR0;
  bit done = 0;

  always #2 clk = ~clk;

  crit_steer_top #(.PC_W(PC_W), .IDX_W(IDX_W), .CYC_W(CYC_W), .THR_INIT(THR0)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_type(req_type),
    .req_pc(req_pc), .req_addr_pred(req_addr_pred), .lane_sel(lane_sel),
    .pred_crit(pred_crit), .trn_valid(trn_valid), .trn_pc(trn_pc),
    .trn_arrive(trn_arrive), .trn_issue(trn_issue), .thr_wr(thr_wr),
    .thr_data(thr_data)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_lane(input int t, input int ap, input int p);
    case (t)
      0: return 0;
      1: return p;
      2: return 1;
      3: return 0;
      4: return ap ? 0 : 1;
      default: return 1;
    endcase
  endfunction

  function automatic string tag(input int t);
    case (t)
      0: return "R6";
      1: return "R8";
      2, 3: return "R5";
      4: return "R7";
      default: return "R9";
    endcase
  endfunction

  function automatic void mdl_train(input int idx, input int slack);
    if (slack < thr) mdl[idx] = (mdl[idx] == 3) ? 3 : mdl[idx] + 1;
    else             mdl[idx] = (mdl[idx] == 0) ? 0 : mdl[idx] - 1;
  endfunction

  task automatic look(input int pc, input int t, input int ap);
    @(negedge clk);
    req_valid = 1; req_pc = PC_W'(pc); req_type = 3'(t); req_addr_pred = ap[0];
    #1;
  endtask

  task automatic train(input int pc, input int slack);
    @(negedge clk);
    trn_valid = 1; trn_pc = PC_W'(pc);
    trn_arrive = 8'd100; trn_issue = CYC_W'(100 + slack);
    @(negedge clk);
    trn_valid = 0;
    mdl_train(pc % N, slack);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < N; i++) mdl[i] = 2;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;

    // R11 idle request is quiet
    look(0, 2, 0);
    req_valid = 0; #1;
    chk("R11 lane", lane_sel, 0);
    chk("R11 pred", pred_crit, 0);

    // R2 reset state: every entry predicts critical
    for (int i = 0; i < N; i++) begin
      look(i, 1, 0);
      chk("R2 reset pred", pred_crit, 1);
    end

    // R3 slack equal to threshold is non-critical: 2 -> 1
    train(5, THR0);
    look(5, 1, 0);
    chk("R3 equal thr", pred_crit, 0);
    // R3 slack one below threshold is critical: 2 -> 3
    train(6, THR0 - 1);
    look(6, 1, 0);
    chk("R3 below thr", pred_crit, 1);

    // R3 / R1 sweep with aliased upper address bits
    for (int k = 0; k < 48; k++) begin
      int idx, slack;
      idx = (k * 3) % N;
      slack = (k * 7) % 12 - 3;
      train(idx + N * (k % 5 + 1), slack);
      look(idx, 1, 0);
      chk("R1 R3 pred", pred_crit, mdl[idx] >= 2 ? 1 : 0);
      chk("R8 lane", lane_sel, mdl[idx] >= 2 ? 1 : 0);
    end

    // R10 same-cycle update and lookup on one entry
    train(2, -1); train(2, -1); train(2, -1);
    train(2, 10);
    chk("R10 setup", mdl[2], 2);
    @(negedge clk);
    trn_valid = 1; trn_pc = 16'd2; trn_arrive = 8'd10; trn_issue = 8'd30;
    req_valid = 1; req_pc = 16'd2; req_type = 3'd1;
    #1;
    chk("R10 old value", pred_crit, 1);
    @(negedge clk);
    trn_valid = 0;
    mdl_train(2, 20);
    #1;
    chk("R10 new value", pred_crit, 0);

    // R4 threshold rewrite
    @(negedge clk);
    thr_wr = 1; thr_data = 8'd10;
    @(negedge clk);
    thr_wr = 0; thr = 10;
    train(4, 0); train(4, 0); train(4, 0);
    train(4, 7);
    look(4, 1, 0);
    chk("R4 slack 7 critical", pred_crit, 1);
    train(4, 10); train(4, 10);
    look(4, 1, 0);
    chk("R4 slack 10 non-critical", pred_crit, 0);

    // R5 R6 R7 R8 R9 full steering sweep
    for (int i = 0; i < N; i++)
      for (int t = 0; t < 8; t++)
        for (int ap = 0; ap < 2; ap++) begin
          int p;
          p = mdl[i] >= 2 ? 1 : 0;
          look(i + N, t, ap);
          chk(tag(t), lane_sel, exp_lane(t, ap, p));
          chk("R2 pred", pred_crit, p);
        end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule